// File: doc/BRIEF.md
# Serial Path-Overhead Byte Inserter

This block sits beside a SONET transmit path-overhead processor. It supplies one overhead byte to that processor over a serial port, bit by bit, in step with the port clock. The processor marks the start of the path overhead with a frame strobe and an enable strobe. The target byte is the fifth one in the overhead, so the block lets four bytes (32 port-clock periods) go by before it sends anything. It then drives the byte most significant bit first, with one bit per clock period. Each bit is launched on a falling edge so that the processor can capture it on the following rising edge.

A host presents the byte on a parallel input and holds an arm level high while insertion is wanted. The byte is captured at the rising edge that starts the wait, so the host may change the input at any later time without harming the byte in flight. An insert-request output is high for exactly the eight bit periods of each byte. The processor can use this output to take the port data, or leave it unconnected if it always takes port data. Once the eighth bit is out, the block goes back to watching the strobes for the next frame.

Top module: `poh_serial_inserter`

## Requirements
- R1: After a synchronous reset, `ser_o` and `ins_o` are low, and they stay low for as long as no start condition occurs.
- R2: A start needs `frame_i`, `enable_i` and `arm_i` all high at the same rising edge while the block is idle. Any combination with at least one of them low starts nothing, and both outputs stay low.
- R3: If the start is seen at rising edge t0, the most significant bit of the byte appears on `ser_o` at the falling edge that follows rising edge t0+32. This is the first falling edge after 32 full port-clock periods of waiting.
- R4: The remaining bits follow in descending bit order, one on each of the next seven falling edges. Bit 7-k of the byte is driven during bit period k, for k from 0 to 7.
- R5: `ins_o` is high exactly during the eight bit periods of a byte and low at all other times. `ser_o` is low whenever `ins_o` is low.
- R6: The byte sent is the value on `byte_i` at the start edge t0. Changes to `byte_i` after t0 do not affect that byte.
- R7: Strobes that arrive while the block is waiting or shifting are ignored. They do not restart or lengthen the current byte.
- R8: Strobes seen at the rising edge t0+40, where the last bit is captured, are ignored. From rising edge t0+41 on, a new start is accepted and follows the same timing.
- R9: A reset asserted during a shift aborts it. Both outputs are low from the next falling edge, and the block is idle once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Port clock; strobes are sampled on its rising edge, data launched on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame strobe from the overhead processor |
| enable_i | input | 1 | Enable strobe from the overhead processor |
| arm_i | input | 1 | Host level that allows insertion on the next frame |
| byte_i | input | BYTE_W (8) | Byte to insert, captured at the start edge |
| ser_o | output | 1 | Serial data bit, most significant bit first |
| ins_o | output | 1 | Insert request, high during the eight bit periods |

## Verification
The hardest situations to reach from the ports are strobes landing inside a byte that is already under way, and a strobe landing on the exact rising edge where the last bit is captured. These decide whether a restart or a dropped frame can happen. The stimulus sends all 256 byte values back to back, with every new start placed on the first idle rising edge. In every other frame it raises the strobes for one edge inside the wait and one edge inside the shift, and it flips `byte_i` right after the start. A separate frame raises the strobes exactly on the edge where the last bit is captured, and the bench then confirms that 40 quiet periods follow.

// File: rtl/poh_ins_pkg.sv
package poh_ins_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SHIFT  = 2'd2
  } ins_state_e;

endpackage

// File: rtl/poh_ins_seq.sv
module poh_ins_seq
  import poh_ins_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int WAIT_CYCLES = 32,
  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1,
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             frame_i,
  input  logic             enable_i,
  input  logic             arm_i,
  output logic             load_o,
  output logic             shift_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  ins_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             start;

  assign start = (st_q == ST_SAMPLE) && frame_i && enable_i && arm_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= ST_SAMPLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_SAMPLE: begin
          if (start) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
          end
        end
        ST_WAIT: begin
          if (cnt_q == CNT_LAST) begin
            st_q  <= ST_SHIFT;
            idx_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (idx_q == IDX_LAST) begin
            st_q  <= ST_SAMPLE;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_SAMPLE;
      endcase
    end
  end

  assign load_o  = start;
  assign shift_o = (st_q == ST_SHIFT);
  assign idx_o   = idx_q;

endmodule

// File: rtl/poh_ins_hold.sv
module poh_ins_hold #(
  parameter int BYTE_W = 8,
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);

  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q <= '0;
    end else if (load_i) begin
      hold_q <= byte_i;
    end
  end

  // bit period k carries byte bit BYTE_W-1-k
  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < BYTE_W; k++) begin
      if (idx_i == IDX_W'(k)) begin
        bit_o = hold_q[BYTE_W-1-k];
      end
    end
  end

endmodule

// File: rtl/poh_ins_launch.sv
module poh_ins_launch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic ser_o,
  output logic ins_o
);

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      ser_o <= 1'b0;
      ins_o <= 1'b0;
    end else begin
      ser_o <= shift_i & bit_i;
      ins_o <= shift_i;
    end
  end

endmodule

// File: rtl/poh_serial_inserter.sv
module poh_serial_inserter #(
  parameter int BYTE_W      = 8,
  parameter int WAIT_CYCLES = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              frame_i,
  input  logic              enable_i,
  input  logic              arm_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ser_o,
  output logic              ins_o
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic             load;
  logic             shift;
  logic [IDX_W-1:0] idx;
  logic             cur_bit;

  poh_ins_seq #(
    .BYTE_W      (BYTE_W),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .frame_i  (frame_i),
    .enable_i (enable_i),
    .arm_i    (arm_i),
    .load_o   (load),
    .shift_o  (shift),
    .idx_o    (idx)
  );

  poh_ins_hold #(
    .BYTE_W (BYTE_W)
  ) u_hold (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load),
    .byte_i (byte_i),
    .idx_i  (idx),
    .bit_o  (cur_bit)
  );

  poh_ins_launch u_launch (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .shift_i (shift),
    .bit_i   (cur_bit),
    .ser_o   (ser_o),
    .ins_o   (ins_o)
  );

endmodule

// File: rtl/poh_serial_inserter_chk.sv
module poh_serial_inserter_chk #(
  parameter int BYTE_W      = 8,
  parameter int WAIT_CYCLES = 32
) (
  input logic clk_i,
  input logic rst_i,
  input logic ser_o,
  input logic ins_o
);

  localparam int HR_W = $clog2(BYTE_W + 2) + 1;
  localparam int LR_W = $clog2(WAIT_CYCLES + 2) + 1;

  logic [HR_W-1:0] high_run;
  logic [LR_W-1:0] low_run;
  logic            seen_high;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      high_run  <= '0;
      low_run   <= LR_W'(WAIT_CYCLES);
      seen_high <= 1'b0;
    end else if (ins_o) begin
      seen_high <= 1'b1;
      low_run   <= '0;
      if (high_run <= HR_W'(BYTE_W)) high_run <= high_run + 1'b1;
    end else begin
      high_run <= '0;
      if (low_run < LR_W'(WAIT_CYCLES)) low_run <= low_run + 1'b1;
    end
  end

  // R5
  ser_gated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !ins_o |-> !ser_o);

  // R5
  burst_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ins_o && high_run != '0) |-> (high_run == HR_W'(BYTE_W)));

  // R5
  burst_max_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ins_o |-> (high_run < HR_W'(BYTE_W)));

  // R3
  wait_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ins_o && high_run == '0 && seen_high) |-> (low_run >= LR_W'(WAIT_CYCLES)));

  // R9
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!ins_o && !ser_o));

endmodule

bind poh_serial_inserter poh_serial_inserter_chk #(
  .BYTE_W      (BYTE_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .ser_o (ser_o),
  .ins_o (ins_o)
);

// File: tb/poh_serial_inserter_bench.sv
module poh_serial_inserter_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame = 1'b0;
  logic       enable = 1'b0;
  logic       arm = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       ser;
  logic       ins;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  poh_serial_inserter u_poh_serial_inserter (
    .clk_i    (clk),
    .rst_i    (rst),
    .frame_i  (frame),
    .enable_i (enable),
    .arm_i    (arm),
    .byte_i   (byte_in),
    .ser_o    (ser),
    .ins_o    (ins)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic strobes(input logic v);
    frame  = v;
    enable = v;
    arm    = v;
  endtask

  // n quiet periods, sampled after each falling edge
  task automatic idle_chk(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #7;
      check({tag, " ins"}, ins, 1'b0);
      check({tag, " ser"}, ser, 1'b0);
    end
  endtask

  // one byte: start at edge t0, sample j periods later after the falling edge
  task automatic do_frame(input logic [7:0] b, input bit probe, input bit tail);
    string tg;
    byte_in = b;
    strobes(1'b1);
    @(posedge clk); #2;
    strobes(1'b0);
    byte_in = ~b;                // R6: later changes must not matter
    #5;
    check("R5 wait ins", ins, 1'b0);
    for (int j = 1; j <= 40; j++) begin
      @(posedge clk); #7;
      tg = probe ? "R7" : "R8";
      if (j >= 32 && j <= 39) begin
        check({tg, " R5 ins"}, ins, 1'b1);
        check((j == 32) ? "R3 R6 msb" : "R4 R6 bit", ser, b[39-j]);
      end else begin
        check({tg, " R5 ins"}, ins, 1'b0);
        check({tg, " R5 ser"}, ser, 1'b0);
      end
      strobes(1'b0);
      if (probe && (j == 9 || j == 34)) strobes(1'b1);   // R7
      if (tail && j == 39) strobes(1'b1);                // R8 edge t0+40
    end
    strobes(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #5;
    // R1
    check("R1 ins", ins, 1'b0);
    check("R1 ser", ser, 1'b0);
    idle_chk(40, "R1");

    // R2: every strobe combination with at least one low
    for (int c = 0; c < 7; c++) begin
      byte_in = 8'hFF;
      frame   = c[0];
      enable  = c[1];
      arm     = c[2];
      @(posedge clk); #2;
      strobes(1'b0);
      #5;
      idle_chk(40, "R2");
    end

    // R3 R4 R6 R7 R8: all byte values, back to back
    for (int v = 0; v < 256; v++) begin
      do_frame(8'(v), v[0], 1'b0);
    end

    // R8: strobe on the last-bit edge is ignored
    do_frame(8'hA5, 1'b0, 1'b1);
    idle_chk(40, "R8");
    do_frame(8'h3C, 1'b0, 1'b0);

    // R9: reset in the middle of a shift
    byte_in = 8'hFF;
    strobes(1'b1);
    @(posedge clk); #2;
    strobes(1'b0);
    for (int j = 1; j <= 34; j++) begin
      @(posedge clk); #7;
    end
    check("R9 pre ins", ins, 1'b1);
    rst = 1'b1;
    @(posedge clk); #7;
    check("R9 ins", ins, 1'b0);
    check("R9 ser", ser, 1'b0);
    rst = 1'b0;
    idle_chk(40, "R9");
    do_frame(8'h81, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule